// File: doc/BRIEF.md
# Scan-Sampled Delay Timer

This block is one timer channel for a controller that evaluates its logic in periodic scans. A free-running tick generator divides the system clock into a base increment picked by a select input. An elapsed counter advances by one on each tick while the timer is running. The timer output is decided by comparing that count with a target number of increments. The activation input is only looked at when the scan strobe is high, so whatever it does between strobes has no effect.

In on-delay mode the output rises once activation has been sampled high for the whole target time. One low sample clears the count and drops the output. In off-delay mode the output follows activation upward at once. After activation is sampled low, the output is held for the target time and then released.

The target is either the raw preset, so that the delay is the increment times the preset, or a preset in milliseconds rounded to the nearest whole increment. The 32-bit elapsed count can be read at all times.

Top module: `scan_delay_timer`

## Requirements
- R1: A synchronous active-high `rst` forces `out` to 0 and `elapsed` to 0 at the next clock edge, including in the middle of a running delay.
- R2: In on-delay mode (`off_mode`=0), after the first edge that samples `act`=1 with `scan`=1, `out` rises after T ticks. At that edge `elapsed` equals T. `out` then stays 1 for as long as every scan sample of `act` is 1.
- R3: In on-delay mode, a single edge with `scan`=1 and `act`=0 sets `elapsed` to 0 and `out` to 0 at that edge.
- R4: Changes of `act` while `scan`=0 are ignored: the count keeps advancing and `out` is unchanged until the next scan sample.
- R5: In off-delay mode (`off_mode`=1), an edge with `scan`=1 and `act`=1 sets `out` to 1 and `elapsed` to 0 at that edge.
- R6: In off-delay mode, once `act` is sampled 0 while `out`=1, `out` stays 1 for T ticks. It falls at the edge where `elapsed` reaches T, and `elapsed` then stays at T.
- R7: In off-delay mode, sampling `act`=1 again during a hold keeps `out` at 1 and clears `elapsed` to 0.
- R8: With `ms_mode`=0, T equals `preset`, so the delay is the increment times the preset. For example, an 8 ms increment with 3000 gives 24 s.
- R9: With `ms_mode`=1, T is `preset`/increment rounded to the nearest integer, with exact halves rounded up. A result of 0 is forced to 1. For example, 100 ms at a 48 ms increment gives T=2 (96 ms).
- R10: `inc_sel` encodes the increment: 0 is 8 ms, 1 is 48 ms, 2 is 1 ms, 3 is 1000 ms. Ticks repeat every increment×`CLK_PER_MS` clock cycles, counted from reset or from the last change of `inc_sel`. So for a fixed select, a delay of T ticks spans between (T-1)·P+1 and T·P clock edges, where P is that period and the sampling edge is counted.
- R11: `elapsed` is 32 bits wide and saturates at T without wrapping. Between clears it never decreases and never grows by more than one per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scan | input | 1 | Scan strobe; `act` is sampled when high |
| act | input | 1 | Activation input |
| off_mode | input | 1 | 0 = on-delay, 1 = off-delay |
| ms_mode | input | 1 | 0 = preset is an increment multiplier, 1 = preset in milliseconds |
| inc_sel | input | 2 | Base increment select (0: 8 ms, 1: 48 ms, 2: 1 ms, 3: 1000 ms) |
| preset | input | 16 | Preset value |
| out | output | 1 | Timer output |
| elapsed | output | 32 | Elapsed increments |

## Verification
The assertions assume that `inc_sel`, `ms_mode`, `preset` and `off_mode` are held steady while a delay runs. They also assume that all inputs are synchronous to `clk`, so that a change of select only restarts the tick phase and never mixes two periods. The stimulus changes these settings only while the timer is idle. It then waits more than two tick periods before starting a measured delay, so every latency falls inside the window that R10 gives. Scan-gating is exercised with sparse one-cycle strobes, and the other tests strobe every cycle.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    localparam int NUM_INC  = 4;
    localparam int SEL_W    = 2;
    localparam int PRESET_W = 16;
    localparam int ELAP_W   = 32;

    typedef enum logic {
        MODE_ON_DELAY  = 1'b0,
        MODE_OFF_DELAY = 1'b1
    } dly_mode_e;

    // Base increment in milliseconds for each select code
    function automatic int unsigned inc_ms(input int unsigned idx);
        case (idx)
            0:       return 8;
            1:       return 48;
            2:       return 1;
            default: return 1000;
        endcase
    endfunction

    function automatic int unsigned max_inc_ms();
        int unsigned m;
        m = 0;
        for (int i = 0; i < NUM_INC; i++) begin
            if (inc_ms(i) > m) m = inc_ms(i);
        end
        return m;
    endfunction

endpackage

// File: rtl/sdt_tick_gen.sv
module sdt_tick_gen
    import sdt_pkg::*;
#(
    parameter int CLK_PER_MS = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int unsigned MAX_PERIOD = max_inc_ms() * CLK_PER_MS;
    localparam int          CNT_W      = $clog2(MAX_PERIOD + 1);

    typedef struct packed {
        logic             tick;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } tg_st_t;

    tg_st_t st_d, st_q;

    // Terminal count (period - 1) per increment select
    logic [CNT_W-1:0] term_lut [NUM_INC];

    for (genvar g = 0; g < NUM_INC; g++) begin : g_period
        assign term_lut[g] = CNT_W'(inc_ms(g) * CLK_PER_MS - 1);
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.sel  = sel_i;
        if (sel_i != st_q.sel) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == term_lut[st_q.sel]) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.tick <= 1'b0;
            st_q.sel  <= sel_i;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    // Independent gap counter: cycles since last tick or restart
    logic [CNT_W:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                    gap_q <= '0;
        else if (sel_i != st_q.sel) gap_q <= '0;
        else if (st_q.tick)         gap_q <= (CNT_W+1)'(1);
        else                        gap_q <= gap_q + (CNT_W+1)'(1);
    end

    AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (gap_q == {1'b0, term_lut[st_q.sel]} + (CNT_W+1)'(1))); // R10

    AST_TICK_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        gap_q <= {1'b0, term_lut[st_q.sel]} + (CNT_W+1)'(1)); // R10

endmodule

// File: rtl/sdt_preset_round.sv
module sdt_preset_round
    import sdt_pkg::*;
(
    input  logic                ms_mode_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [PRESET_W-1:0] preset_i,
    output logic [PRESET_W-1:0] target_o
);

    logic [PRESET_W-1:0] rnd [NUM_INC];

    // One constant-divisor rounding unit per increment
    for (genvar g = 0; g < NUM_INC; g++) begin : g_round
        localparam int unsigned INC = inc_ms(g);
        logic [PRESET_W:0] biased;
        logic [PRESET_W:0] quot;
        assign biased = {1'b0, preset_i} + (PRESET_W+1)'(INC / 2);
        assign quot   = biased / (PRESET_W+1)'(INC);
        assign rnd[g] = quot[PRESET_W-1:0];
    end

    always_comb begin
        if (!ms_mode_i) begin
            target_o = preset_i;
        end else begin
            target_o = rnd[sel_i];
            if (target_o == '0) target_o = PRESET_W'(1);
        end
    end

endmodule

// File: rtl/sdt_core.sv
module sdt_core
    import sdt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                scan_i,
    input  logic                act_i,
    input  logic                off_mode_i,
    input  logic [PRESET_W-1:0] target_i,
    output logic                out_o,
    output logic [ELAP_W-1:0]   elap_o
);

    typedef struct packed {
        logic              act;
        logic              out;
        logic [ELAP_W-1:0] elap;
    } core_st_t;

    core_st_t          st_d, st_q;
    dly_mode_e         mode;
    logic [ELAP_W-1:0] tgt;
    logic              adv;

    assign mode = dly_mode_e'(off_mode_i);
    assign tgt  = ELAP_W'(target_i);

    always_comb begin
        st_d = st_q;
        if (scan_i) st_d.act = act_i;
        adv = tick_i && (st_q.elap < tgt);
        if (mode == MODE_ON_DELAY) begin
            if (!st_d.act)  st_d.elap = '0;
            else if (adv)   st_d.elap = st_q.elap + ELAP_W'(1);
            st_d.out = st_d.act && (st_d.elap >= tgt);
        end else begin
            if (scan_i && act_i) begin
                st_d.elap = '0;
                st_d.out  = 1'b1;
            end else if (!st_d.act && st_q.out) begin
                if (adv) st_d.elap = st_q.elap + ELAP_W'(1);
                st_d.out = (st_d.elap < tgt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.act  <= 1'b0;
            st_q.out  <= 1'b0;
            st_q.elap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o  = st_q.out;
    assign elap_o = st_q.elap;

    AST_ELAP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (elap_o != '0) |=> (elap_o == '0 || elap_o >= $past(elap_o))); // R11

    AST_ELAP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (elap_o <= $past(elap_o) + ELAP_W'(1))); // R11

    AST_ONDLY_LOW_SCAN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!off_mode_i && scan_i && !act_i) |=> (!out_o && elap_o == '0)); // R3

    AST_OFFDLY_HIGH_SCAN_SETS: assert property (@(posedge clk) disable iff (rst)
        (off_mode_i && scan_i && act_i) |=> (out_o && elap_o == '0)); // R5

endmodule

// File: rtl/scan_delay_timer.sv
module scan_delay_timer
    import sdt_pkg::*;
#(
    parameter int CLK_PER_MS = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scan,
    input  logic                act,
    input  logic                off_mode,
    input  logic                ms_mode,
    input  logic [SEL_W-1:0]    inc_sel,
    input  logic [PRESET_W-1:0] preset,
    output logic                out,
    output logic [ELAP_W-1:0]   elapsed
);

    logic                tick;
    logic [PRESET_W-1:0] target;

    sdt_tick_gen #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (inc_sel),
        .tick_o (tick)
    );

    sdt_preset_round u_round (
        .ms_mode_i (ms_mode),
        .sel_i     (inc_sel),
        .preset_i  (preset),
        .target_o  (target)
    );

    sdt_core u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .scan_i     (scan),
        .act_i      (act),
        .off_mode_i (off_mode),
        .target_i   (target),
        .out_o      (out),
        .elap_o     (elapsed)
    );

endmodule

// File: tb/scan_delay_timer_tb.sv
module scan_delay_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 2;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic        ms;
        logic [1:0]  sel;
        logic [15:0] pre;
        logic [31:0] t;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 16'd5,    32'd5},
        '{1'b1, 2'd1, 16'd100,  32'd2},
        '{1'b1, 2'd1, 16'd72,   32'd2},
        '{1'b1, 2'd1, 16'd71,   32'd1},
        '{1'b1, 2'd1, 16'd10,   32'd1},
        '{1'b1, 2'd0, 16'd100,  32'd13},
        '{1'b0, 2'd2, 16'd3,    32'd3},
        '{1'b1, 2'd2, 16'd7,    32'd7},
        '{1'b0, 2'd3, 16'd1,    32'd1},
        '{1'b0, 2'd0, 16'd3000, 32'd3000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scan = 1'b1;
    logic        act = 1'b0;
    logic        off_mode = 1'b0;
    logic        ms_mode = 1'b0;
    logic [1:0]  inc_sel = 2'd0;
    logic [15:0] preset = 16'd0;
    logic        out;
    logic [31:0] elapsed;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_delay_timer #(.CLK_PER_MS(CPM)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scan     (scan),
        .act      (act),
        .off_mode (off_mode),
        .ms_mode  (ms_mode),
        .inc_sel  (inc_sel),
        .preset   (preset),
        .out      (out),
        .elapsed  (elapsed)
    );

    function automatic int bench_inc_ms(input int s);
        case (s)
            0:       return 8;
            1:       return 48;
            2:       return 1;
            default: return 1000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic negs(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int p, t, c;
        string rq;
        p  = bench_inc_ms(int'(v.sel)) * CPM;
        t  = int'(v.t);
        rq = v.ms ? "R9" : "R8";
        off_mode = 1'b0; scan = 1'b1; act = 1'b0;
        ms_mode = v.ms; inc_sel = v.sel; preset = v.pre;
        negs(2 * p + 4);
        // On-delay
        act = 1'b1;
        c = 0;
        while (c <= t * p + 4) begin
            @(posedge clk); c++;
            @(negedge clk);
            if (out) break;
        end
        chk(out == 1'b1 && c >= (t - 1) * p + 1 && c <= t * p, "R2 R10",
            "on-delay latency in edges (expected is upper bound)", c, t * p);
        chk(elapsed == v.t, rq, "elapsed at on-delay output rise", elapsed, t);
        negs(3 * p);
        chk(out == 1'b1 && elapsed == v.t, "R11", "saturated elapsed while held", elapsed, t);
        // Off-delay
        off_mode = 1'b1;
        negs(1);
        chk(out == 1'b1 && elapsed == 0, "R5", "off-delay set, elapsed", elapsed, 0);
        act = 1'b0;
        c = 0;
        while (c <= t * p + 4) begin
            @(posedge clk); c++;
            @(negedge clk);
            if (!out) break;
        end
        chk(out == 1'b0 && c >= (t - 1) * p + 1 && c <= t * p, "R6 R10",
            "off-delay hold in edges (expected is upper bound)", c, t * p);
        chk(elapsed == v.t, "R6", "elapsed at off-delay release", elapsed, t);
    endtask

    initial begin
        logic [31:0] e1, e2;
        negs(3);
        chk(out == 1'b0 && elapsed == 0, "R1", "reset state elapsed", elapsed, 0);
        rst = 1'b0;
        negs(2);

        // Table-driven walk over rounding, multiplier and increment cases
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R4 / R3: sparse scan strobes, 1 ms increment, 50 increments
        off_mode = 1'b0; ms_mode = 1'b0; inc_sel = 2'd2; preset = 16'd50;
        scan = 1'b0; act = 1'b0;
        negs(10);
        act = 1'b1; scan = 1'b1;
        negs(1);
        scan = 1'b0;
        negs(20);
        e1 = elapsed;
        chk(e1 > 0, "R2", "elapsed advancing after one high sample", e1, 1);
        act = 1'b0;
        negs(5);
        act = 1'b1;
        negs(1);
        e2 = elapsed;
        chk(e2 > e1 && out == 1'b0, "R4", "elapsed after unsampled low", e2, e1 + 1);
        act = 1'b0; scan = 1'b1;
        negs(1);
        scan = 1'b0;
        chk(elapsed == 0 && out == 1'b0, "R3", "elapsed after one low scan", elapsed, 0);

        // R7: re-activation during an off-delay hold
        off_mode = 1'b1; scan = 1'b1; act = 1'b1;
        negs(2);
        act = 1'b0;
        negs(20);
        chk(out == 1'b1 && elapsed > 0, "R6", "out held mid-hold, elapsed", elapsed, 1);
        act = 1'b1;
        negs(1);
        chk(out == 1'b1 && elapsed == 0, "R7", "re-arm during hold, elapsed", elapsed, 0);
        act = 1'b0;
        negs(10);
        rst = 1'b1;
        negs(1);
        chk(out == 1'b0 && elapsed == 0, "R1", "reset during hold, out", out, 0);
        rst = 1'b0;
        negs(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-all: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule